// File: doc/BRIEF.md
# Cascaded Timer Real-Time Clock

This block keeps a 12-hour time of day from a fixed 2 MHz input clock. Three down-counters are chained. The first divides the input clock to a 25 ms tick. The second divides that tick to one pulse per second. The third counts seconds across a 12-hour span. Every counter is a rate generator: on reaching one it produces a single-cycle pulse, and on its next enable it reloads its programmed value by itself.

Each one-second pulse raises a one-cycle interrupt. It also starts a fixed-length conversion. The conversion takes the elapsed seconds (span minus the third counter's count) and splits them into hours, minutes and seconds. The result is written as two BCD digits per field into three latched output ports, and all three ports change in the same clock cycle. Software can reprogram each counter by writing its 16-bit reload value over an 8-bit bus, low byte first and high byte second. Programming the third counter therefore presets the displayed time.

Top module: `rtc_cascade`

## Requirements
- R1: During and after synchronous reset, each counter holds its parameter reload (defaults 50000, 40, 43200), irq is low, the ports read seconds 8'h00, minutes 8'h00, hours 8'h12, and every stage's byte pointer expects a low byte.
- R2: A counter enabled with count N > 1 steps to N-1. An enabled counter at count 1 raises its terminal pulse for that cycle and takes its reload value on that edge, so its period is the reload value in enables (reload values are 2 or more).
- R3: The first counter is enabled on every clock. The second is enabled only on the first counter's terminal cycles, and the third only on the second counter's terminal cycles. When the first two reloads are A and B, irq therefore repeats every A*B clocks.
- R4: A write with wr_addr 0, 1 or 2 selects the first, second or third counter, and wr_addr 3 is ignored. Each selected stage takes its first byte as the low byte and its next byte as the high byte. On the high byte both the reload and the count take {high, low}. A load takes priority over counting and suppresses that stage's terminal pulse in that cycle.
- R5: irq is high for exactly the one clock cycle that follows each terminal cycle of the second counter.
- R6: Each one-second pulse converts elapsed = 43200 - third count into h = elapsed/3600, m = (elapsed mod 3600)/60 and s = elapsed mod 60. Each value goes out as two BCD digits, tens in bits 7:4 and units in bits 3:0: s on port_sec, m on port_min, h on port_hr.
- R7: An hour value of 0 is shown as 8'h12 on port_hr.
- R8: All three ports change together on the 31st rising edge after the edge that raises irq, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2 MHz input clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe for reload programming |
| wr_addr | input | 2 | Stage select: 0 fast, 1 seconds, 2 span, 3 none |
| wr_data | input | 8 | Reload byte, low byte then high byte |
| irq | output | 1 | One-cycle update interrupt, once per second |
| port_sec | output | 8 | Latched BCD seconds |
| port_min | output | 8 | Latched BCD minutes |
| port_hr | output | 8 | Latched BCD hours, 01 to 12 |

## Verification
The embedded properties check the following on every clock:
- the count stepping and reload at terminal of each stage;
- that a counter holds when neither enabled nor loaded;
- the single-cycle irq;
- valid BCD digits and a nonzero hour on the ports;
- ports that change only on the conversion's done strobe;
- a divider remainder below its divisor.

Only the bench's scenarios can show other properties. These are the cascade periods after reprogramming, the low/high byte order and the ignored address, the exact conversion latency, the converted values near the end of the span, and the third counter's wrap back to its preset.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int BYTE_W   = 8;
  localparam int N_STAGES = 3;

  typedef enum logic [1:0] {
    SEL_FAST = 2'd0,
    SEL_SEC  = 2'd1,
    SEL_SPAN = 2'd2,
    SEL_NONE = 2'd3
  } stage_sel_e;

  // two BCD digits of a value below 100
  function automatic logic [7:0] to_bcd2(input logic [15:0] v);
    logic [15:0] tens;
    logic [15:0] units;
    tens  = v / 16'd10;
    units = v % 16'd10;
    return {tens[3:0], units[3:0]};
  endfunction

endpackage

// File: rtl/rtc_rate_stage.sv
module rtc_rate_stage #(
  parameter int            CW   = 16,
  parameter logic [CW-1:0] INIT = CW'(2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  output logic          term,
  output logic [CW-1:0] count
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] reload_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= INIT;
      reload_q <= INIT;
    end else if (ld) begin
      cnt_q    <= ld_val;
      reload_q <= ld_val;
    end else if (en) begin
      cnt_q <= (cnt_q == CW'(1)) ? reload_q : cnt_q - CW'(1);
    end
  end

  assign term  = en & ~ld & (cnt_q == CW'(1));
  assign count = cnt_q;

  // R2: terminal count reloads on the same edge
  p_reload_on_terminal_r2: assert property (@(posedge clk) disable iff (rst)
    term |=> cnt_q == $past(reload_q));

  // R2: an enabled count above one steps down by one
  p_step_down_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !ld && cnt_q != CW'(1)) |=> cnt_q == $past(cnt_q) - CW'(1));

  // R3: without enable or load the count holds
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (!en && !ld) |=> $stable(cnt_q));

endmodule

// File: rtl/rtc_serial_div.sv
module rtc_serial_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem,
  output logic         done
);

  localparam int SW = $clog2(W + 1);

  logic [SW-1:0] steps_q;
  logic [W:0]    trial;
  logic [W:0]    dvs_ext;

  assign trial   = {rem, quo[W-1]};
  assign dvs_ext = {1'b0, divisor};

  always_ff @(posedge clk) begin
    if (rst) begin
      quo     <= '0;
      rem     <= '0;
      steps_q <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        quo     <= dividend;
        rem     <= '0;
        steps_q <= SW'(W);
      end else if (steps_q != '0) begin
        steps_q <= steps_q - SW'(1);
        if (trial >= dvs_ext) begin
          rem <= W'(trial - dvs_ext);
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= trial[W-1:0];
          quo <= {quo[W-2:0], 1'b0};
        end
        if (steps_q == SW'(1)) done <= 1'b1;
      end
    end
  end

  // R6: a finished division leaves a remainder below the divisor
  p_rem_below_divisor_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> rem < divisor);

endmodule

// File: rtl/rtc_cascade.sv
module rtc_cascade #(
  parameter int CW       = 16,
  parameter int PRE_INIT = 50000,
  parameter int SEC_INIT = 40,
  parameter int SPAN     = 43200
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       irq,
  output logic [7:0] port_sec,
  output logic [7:0] port_min,
  output logic [7:0] port_hr
);
  import rtc_pkg::*;

  localparam int HOUR_SEC = 3600;
  localparam int MIN_SEC  = 60;
  localparam int MW       = $clog2(HOUR_SEC);

  logic [BYTE_W-1:0] lo_byte_q [N_STAGES];
  logic [N_STAGES-1:0] hi_pend_q;
  logic [N_STAGES-1:0] en_s, ld_s, term_s;
  logic [CW-1:0]       cnt_s [N_STAGES];

  // byte pointer per stage: low byte, then high byte
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_pend_q <= '0;
      for (int i = 0; i < N_STAGES; i++) lo_byte_q[i] <= '0;
    end else if (wr_en && wr_addr != SEL_NONE) begin
      for (int i = 0; i < N_STAGES; i++) begin
        if (wr_addr == 2'(i)) begin
          if (!hi_pend_q[i]) lo_byte_q[i] <= wr_data;
          hi_pend_q[i] <= ~hi_pend_q[i];
        end
      end
    end
  end

  assign en_s[0] = 1'b1;
  assign en_s[1] = term_s[0];
  assign en_s[2] = term_s[1];

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    localparam int INIT_G = (g == 0) ? PRE_INIT : (g == 1) ? SEC_INIT : SPAN;
    assign ld_s[g] = wr_en && (wr_addr == 2'(g)) && hi_pend_q[g];
    rtc_rate_stage #(.CW(CW), .INIT(CW'(INIT_G))) i_stage (
      .clk    (clk),
      .rst    (rst),
      .en     (en_s[g]),
      .ld     (ld_s[g]),
      .ld_val (CW'({wr_data, lo_byte_q[g]})),
      .term   (term_s[g]),
      .count  (cnt_s[g])
    );
    // R2: reload values of one or more keep every count nonzero
    p_count_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
      cnt_s[g] != '0);
  end

  // one-second strobe
  logic irq_q;
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= term_s[1];
  end
  assign irq = irq_q;

  // elapsed seconds -> hours, then remainder -> minutes and seconds
  logic [CW-1:0] elapsed;
  logic [CW-1:0] hr_quo, hr_rem;
  logic [MW-1:0] mn_quo, mn_rem;
  logic          hr_done, mn_done;

  assign elapsed = CW'(SPAN) - cnt_s[2];

  rtc_serial_div #(.W(CW)) i_div_hr (
    .clk      (clk),
    .rst      (rst),
    .start    (irq_q),
    .dividend (elapsed),
    .divisor  (CW'(HOUR_SEC)),
    .quo      (hr_quo),
    .rem      (hr_rem),
    .done     (hr_done)
  );

  rtc_serial_div #(.W(MW)) i_div_mn (
    .clk      (clk),
    .rst      (rst),
    .start    (hr_done),
    .dividend (hr_rem[MW-1:0]),
    .divisor  (MW'(MIN_SEC)),
    .quo      (mn_quo),
    .rem      (mn_rem),
    .done     (mn_done)
  );

  logic [15:0] hr_show;
  assign hr_show = (hr_quo == '0) ? 16'd12 : 16'(hr_quo);

  always_ff @(posedge clk) begin
    if (rst) begin
      port_sec <= 8'h00;
      port_min <= 8'h00;
      port_hr  <= 8'h12;
    end else if (mn_done) begin
      port_sec <= to_bcd2(16'(mn_rem));
      port_min <= to_bcd2(16'(mn_quo));
      port_hr  <= to_bcd2(hr_show);
    end
  end

  // R5: the interrupt lasts one cycle
  p_irq_single_r5: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R8: ports move only together on conversion done
  p_ports_atomic_r8: assert property (@(posedge clk) disable iff (rst)
    !mn_done |=> ($stable(port_sec) && $stable(port_min) && $stable(port_hr)));

  // R6: every digit is a valid BCD digit
  p_bcd_digits_r6: assert property (@(posedge clk) disable iff (rst)
    (port_sec[3:0] <= 4'd9) && (port_sec[7:4] <= 4'd5) &&
    (port_min[3:0] <= 4'd9) && (port_min[7:4] <= 4'd5) &&
    (port_hr[3:0]  <= 4'd9) && (port_hr[7:4]  <= 4'd1));

  // R7: hour zero never reaches the port
  p_hour_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    port_hr != 8'h00);

endmodule

// File: tb/test_rtc_cascade.sv
module test_rtc_cascade;

  localparam int PRE  = 7;
  localparam int SECD = 6;
  localparam int SPAN = 43200;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       irq;
  logic [7:0] port_sec, port_min, port_hr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit started = 0;

  always #2 clk = ~clk;

  rtc_cascade #(.PRE_INIT(PRE), .SEC_INIT(SECD), .SPAN(SPAN)) i_rtc_cascade (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq(irq), .port_sec(port_sec), .port_min(port_min), .port_hr(port_hr)
  );

  function automatic logic [7:0] bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int  mc[3], mrl[3], mlo[3];
  bit  mhi[3];
  bit  mirq;
  int  pend, pval;
  logic [7:0] ms, mm, mh;

  always @(posedge clk) begin : model
    bit ld[3];
    int v[3];
    bit en;
    bit t[3];
    started = 1;
    if (rst) begin
      mc[0] = PRE; mc[1] = SECD; mc[2] = SPAN;
      mrl[0] = PRE; mrl[1] = SECD; mrl[2] = SPAN;
      for (int s = 0; s < 3; s++) begin mhi[s] = 0; mlo[s] = 0; end
      mirq = 0; pend = 0; pval = 0;
      ms = 8'h00; mm = 8'h00; mh = 8'h12;
    end else begin
      for (int s = 0; s < 3; s++) begin
        ld[s] = 0; v[s] = 0;
        if (wr_en && wr_addr == 2'(s)) begin
          if (mhi[s]) begin
            ld[s] = 1; v[s] = int'(wr_data) * 256 + mlo[s]; mhi[s] = 0;
          end else begin
            mlo[s] = int'(wr_data); mhi[s] = 1;
          end
        end
      end
      en = 1;
      for (int s = 0; s < 3; s++) begin
        t[s] = en && !ld[s] && (mc[s] == 1);
        if (ld[s]) begin mc[s] = v[s]; mrl[s] = v[s]; end
        else if (en) mc[s] = (mc[s] == 1) ? mrl[s] : mc[s] - 1;
        en = t[s];
      end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          ms = bcd(pval % 60);
          mm = bcd((pval % 3600) / 60);
          mh = bcd((pval / 3600 == 0) ? 12 : pval / 3600);
        end
      end
      if (t[1]) begin pend = 31; pval = SPAN - mc[2]; end
      mirq = t[1];
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (started) begin
      chk(irq == mirq, "R5 irq vs model", int'(irq), int'(mirq));
      chk({port_hr, port_min, port_sec} == {mh, mm, ms}, "R8 ports vs model",
          int'({port_hr, port_min, port_sec}), int'({mh, mm, ms}));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_irq();
    @(negedge clk);
    while (!irq) @(negedge clk);
  endtask

  task automatic period(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!irq);
  endtask

  task automatic check_time(input string tag, input logic [7:0] h,
                            input logic [7:0] m, input logic [7:0] s);
    wait_irq();
    repeat (32) @(negedge clk);
    chk({port_hr, port_min, port_sec} == {h, m, s}, tag,
        int'({port_hr, port_min, port_sec}), int'({h, m, s}));
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R1 irq in reset", int'(irq), 0);
    chk({port_hr, port_min, port_sec} == 24'h120000, "R1 ports in reset",
        int'({port_hr, port_min, port_sec}), 'h120000);
    rst = 1'b0;

    // R7: hour zero displayed as 12, first second elapsed
    check_time("R7 first second 12:00:01", 8'h12, 8'h00, 8'h01);

    // R3: default cascade period PRE*SECD
    wait_irq();
    period(n);
    chk(n == PRE * SECD, "R3 default irq period", n, PRE * SECD);

    // R4: reprogram stages 0 and 1, low byte then high byte
    wr(2'd0, 8'h0A); wr(2'd0, 8'h00);
    wr(2'd1, 8'h05); wr(2'd1, 8'h00);
    wait_irq();
    period(n);
    chk(n == 50, "R4 reprogrammed period", n, 50);

    // R4: address 3 is ignored and leaves byte pointers alone
    wr(2'd3, 8'h01);
    wait_irq();
    period(n);
    chk(n == 50, "R4 address 3 ignored", n, 50);

    // R6: preset third counter to 100 -> 43101 s = 11:58:21
    wr(2'd2, 8'h64); wr(2'd2, 8'h00);
    check_time("R6 preset 11:58:21", 8'h11, 8'h58, 8'h21);

    // R2: third counter wraps to its reload value
    wr(2'd3, 8'hFF);
    wr(2'd2, 8'h02); wr(2'd2, 8'h00);
    check_time("R6 end of span 11:59:59", 8'h11, 8'h59, 8'h59);
    check_time("R2 wrap to preset 11:59:58", 8'h11, 8'h59, 8'h58);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule